// File: doc/BRIEF.md
# DMA Channel Trigger and Completion Controller

This block sits in front of a DMA transfer engine and decides which channel runs next. Each channel can be started in three ways. A peripheral event line can fire. Software can write a set mask. The completion of another channel can chain into it. Each source has its own flag bank per channel. Peripheral flags only request service when the channel's enable bit is set. The lowest-numbered requesting channel is offered to the engine through a valid/ready start handshake.

When the engine reports a completion, the block looks up the channel's option word. That word holds a completion code and four enables: interrupt and chain, each for final and for intermediate completions. The code selects which interrupt-pending bit to set, which chain flag to set, or both. A chain flag is a start trigger for the channel the code names, so one channel's completion can start another. A single interrupt output is high while any pending bit is enabled. Software finds the finished channel by reading the pending register, and clears pending bits by writing ones.

Top module: `dma_trig_ctrl`

## Requirements
- R1: After reset, all flag, enable, pending, missed and option registers read zero, and `start_valid_o` and `irq_o` are low.
- R2: A high `evt_i` bit latches the event flag (read address 0) whether or not the channel is enabled. Only flags whose enable bit (address 1) is set request a start.
- R3: Writing to address 2 sets the software flag of every channel whose data bit is 1. Bits written as 0 have no effect.
- R4: When no offer is outstanding, the lowest-numbered requesting channel is offered. `start_valid_o` rises on the second clock edge after the trigger is presented.
- R5: An offer holds `start_ch_o` steady until `start_ready_i`. On acceptance, the event, software and chain flags of that channel clear, unless a new trigger for that source arrives in the same cycle. No offer is made in the cycle after an acceptance.
- R6: An option word is written at address 16+channel, with the completion code in bits 7:0. A completion sets interrupt-pending bit `code` (read address 4) when it is final and option bit 8 is set, or when it is intermediate and option bit 10 is set.
- R7: A final completion with option bit 9, or an intermediate one with option bit 11, sets chain flag `code` (read address 3), which then requests a start of that channel. The completed channel's option word is left unchanged. Codes of NUM_CH or more set nothing.
- R8: `irq_o` is high exactly when some pending bit has its enable bit (address 6) set. Writing ones to address 5 clears those pending bits, and a set in the same cycle wins.
- R9: A trigger that reaches a source flag that is already set and not being cleared sets that channel's missed bit (read address 7). Writing ones to address 7 clears missed bits, and a new miss in the same cycle wins.
- R10: Writes to addresses 0, 3 and 4 are ignored. Reads of addresses 5, 8 to 15 and unmapped option slots return zero. Option words read back as written, in the low 12 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_CH | Peripheral event lines, one per channel |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | DATA_W | Register read data (combinational) |
| start_valid_o | output | 1 | Start request offered to the engine |
| start_ready_i | input | 1 | Engine accepts the start request |
| start_ch_o | output | CH_W | Channel being offered |
| done_valid_i | input | 1 | Completion report strobe |
| done_ch_i | input | CH_W | Channel that completed |
| done_final_i | input | 1 | 1 for a final completion, 0 for an intermediate one |
| irq_o | output | 1 | Combined completion interrupt |

## Verification
The embedded assertions watch the handshake and flag invariants on every cycle. They check that a stalled offer holds its channel, that an offered channel was requesting and nothing lower was, that every set lands in its flag, and that an acceptance leaves a one-cycle gap. They also check that routed completions land in the pending and chain registers and that missed events are recorded. Some properties are visible only in the bench's scenarios: the exact register read map, that writes to read-only addresses are ignored, and the ordering across several simultaneous triggers. So are the end-to-end chain from one channel's completion to another's start, and the clear-versus-set races on the pending and missed registers. All of these are compared cycle by cycle against a behavioural model.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int A_EVT      = 0;
  localparam int A_EN       = 1;
  localparam int A_SWSET    = 2;
  localparam int A_CHAIN    = 3;
  localparam int A_IPEND    = 4;
  localparam int A_ICLR     = 5;
  localparam int A_IEN      = 6;
  localparam int A_MISS     = 7;
  localparam int A_OPT_BASE = 16;

  // option word: code[7:0], fin_int[8], fin_chn[9], mid_int[10], mid_chn[11]
  typedef struct packed {
    logic       mid_chn;
    logic       mid_int;
    logic       fin_chn;
    logic       fin_int;
    logic [7:0] code;
  } ch_opt_t;

  localparam int OPT_W = $bits(ch_opt_t);
endpackage

// File: rtl/dtc_flag_bank.sv
module dtc_flag_bank #(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] miss_o
);
  logic [N-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (q & ~clr_i) | set_i;
  end

  assign flag_o = q;
  assign miss_o = set_i & q & ~clr_i;

  assert_set_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((q & $past(set_i)) == $past(set_i)));

  assert_clr_takes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/dtc_prio_arb.sv
module dtc_prio_arb #(
  parameter int N  = 16,
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [CW-1:0] ch_o,
  output logic [N-1:0]  clr_o
);
  logic [CW-1:0] pick;
  logic          any;
  logic [N-1:0]  below;

  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        pick = CW'(i);
        any  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ch_o    <= '0;
    end else if (valid_o) begin
      if (ready_i) valid_o <= 1'b0;
    end else if (any) begin
      valid_o <= 1'b1;
      ch_o    <= pick;
    end
  end

  assign clr_o = (valid_o && ready_i) ? (N'(1) << ch_o) : '0;
  assign below = (N'(1) << ch_o) - N'(1);

  assert_offer_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(ch_o)));

  assert_gap_after_accept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i) |=> !valid_o);

  assert_lowest_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> ((($past(req_i) & below) == '0) &&
                        (($past(req_i) & (N'(1) << ch_o)) != '0)));
endmodule

// File: rtl/dtc_cmpl_route.sv
module dtc_cmpl_route #(
  parameter int N = 16
) (
  input  logic         valid_i,
  input  logic         final_i,
  input  logic [7:0]   code_i,
  input  logic         fin_int_i,
  input  logic         fin_chn_i,
  input  logic         mid_int_i,
  input  logic         mid_chn_i,
  output logic [N-1:0] int_set_o,
  output logic [N-1:0] chn_set_o
);
  logic int_en, chn_en;

  assign int_en = final_i ? fin_int_i : mid_int_i;
  assign chn_en = final_i ? fin_chn_i : mid_chn_i;

  // out-of-range codes shift to zero
  assign int_set_o = (valid_i && int_en) ? (N'(1) << code_i) : '0;
  assign chn_set_o = (valid_i && chn_en) ? (N'(1) << code_i) : '0;
endmodule

// File: rtl/dma_trig_ctrl.sv
module dma_trig_ctrl
  import dtc_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] evt_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              start_valid_o,
  input  logic              start_ready_i,
  output logic [CH_W-1:0]   start_ch_o,
  input  logic              done_valid_i,
  input  logic [CH_W-1:0]   done_ch_i,
  input  logic              done_final_i,
  output logic              irq_o
);
  localparam int N = NUM_CH;

  initial begin
    if (DATA_W < N || DATA_W < OPT_W || A_OPT_BASE + N > (1 << ADDR_W))
      $error("dma_trig_ctrl: parameter set out of range");
  end

  logic [N-1:0] en_q, ie_q, ip_q, ms_q;
  ch_opt_t      opt_q [N];
  logic [N-1:0] wdat;
  logic [N-1:0] evt_flag, sw_flag, chn_flag;
  logic [N-1:0] evt_miss, sw_miss, chn_miss, miss_any;
  logic [N-1:0] sw_set, chn_set, int_set, acc_clr;
  logic [N-1:0] req;
  ch_opt_t      dopt;

  function automatic logic wr_hit(input int a);
    return wr_en_i && (wr_addr_i == ADDR_W'(a));
  endfunction

  assign wdat   = wr_data_i[N-1:0];
  assign sw_set = wr_hit(A_SWSET) ? wdat : '0;
  assign dopt   = opt_q[done_ch_i];

  dtc_cmpl_route #(.N(N)) u_route (
    .valid_i   (done_valid_i),
    .final_i   (done_final_i),
    .code_i    (dopt.code),
    .fin_int_i (dopt.fin_int),
    .fin_chn_i (dopt.fin_chn),
    .mid_int_i (dopt.mid_int),
    .mid_chn_i (dopt.mid_chn),
    .int_set_o (int_set),
    .chn_set_o (chn_set)
  );

  dtc_flag_bank #(.N(N)) u_evt_bank (
    .clk_i, .rst_ni, .set_i(evt_i), .clr_i(acc_clr), .flag_o(evt_flag), .miss_o(evt_miss)
  );
  dtc_flag_bank #(.N(N)) u_sw_bank (
    .clk_i, .rst_ni, .set_i(sw_set), .clr_i(acc_clr), .flag_o(sw_flag), .miss_o(sw_miss)
  );
  dtc_flag_bank #(.N(N)) u_chn_bank (
    .clk_i, .rst_ni, .set_i(chn_set), .clr_i(acc_clr), .flag_o(chn_flag), .miss_o(chn_miss)
  );

  assign req      = (evt_flag & en_q) | sw_flag | chn_flag;
  assign miss_any = evt_miss | sw_miss | chn_miss;

  dtc_prio_arb #(.N(N), .CW(CH_W)) u_arb (
    .clk_i, .rst_ni,
    .req_i   (req),
    .ready_i (start_ready_i),
    .valid_o (start_valid_o),
    .ch_o    (start_ch_o),
    .clr_o   (acc_clr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
      ie_q <= '0;
      ip_q <= '0;
      ms_q <= '0;
      for (int i = 0; i < N; i++) opt_q[i] <= '0;
    end else begin
      if (wr_hit(A_EN))  en_q <= wdat;
      if (wr_hit(A_IEN)) ie_q <= wdat;
      ip_q <= (ip_q & ~(wr_hit(A_ICLR) ? wdat : '0)) | int_set;
      ms_q <= (ms_q & ~(wr_hit(A_MISS) ? wdat : '0)) | miss_any;
      for (int i = 0; i < N; i++)
        if (wr_hit(A_OPT_BASE + i)) opt_q[i] <= ch_opt_t'(wr_data_i[OPT_W-1:0]);
    end
  end

  assign irq_o = |(ip_q & ie_q);

  always_comb begin
    rd_data_o = '0;
    if      (rd_addr_i == ADDR_W'(A_EVT))   rd_data_o = DATA_W'(evt_flag);
    else if (rd_addr_i == ADDR_W'(A_EN))    rd_data_o = DATA_W'(en_q);
    else if (rd_addr_i == ADDR_W'(A_SWSET)) rd_data_o = DATA_W'(sw_flag);
    else if (rd_addr_i == ADDR_W'(A_CHAIN)) rd_data_o = DATA_W'(chn_flag);
    else if (rd_addr_i == ADDR_W'(A_IPEND)) rd_data_o = DATA_W'(ip_q);
    else if (rd_addr_i == ADDR_W'(A_IEN))   rd_data_o = DATA_W'(ie_q);
    else if (rd_addr_i == ADDR_W'(A_MISS))  rd_data_o = DATA_W'(ms_q);
    else if (rd_addr_i >= ADDR_W'(A_OPT_BASE) && rd_addr_i < ADDR_W'(A_OPT_BASE + N))
      rd_data_o = DATA_W'(opt_q[CH_W'(rd_addr_i - ADDR_W'(A_OPT_BASE))]);
  end

  assert_ipend_lands_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_set != '0) |=> ((ip_q & $past(int_set)) == $past(int_set)));

  assert_chain_requests_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chn_set != '0) |=> ((req & $past(chn_set)) == $past(chn_set)));

  assert_irq_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(int_set != '0) || $past(wr_hit(A_IEN))));

  assert_miss_recorded_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_any != '0) |=> ((ms_q & $past(miss_any)) == $past(miss_any)));
endmodule

// File: tb/dma_trig_ctrl_bench.sv
module dma_trig_ctrl_bench;
  localparam int N  = 16;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  evt = '0;
  logic          we = 1'b0;
  logic [AW-1:0] wa = '0;
  logic [DW-1:0] wd = '0;
  logic [AW-1:0] ra = '0;
  logic [DW-1:0] rd;
  logic          sv;
  logic          rdy = 1'b0;
  logic [CW-1:0] sch;
  logic          dv = 1'b0;
  logic [CW-1:0] dch = '0;
  logic          dfin = 1'b0;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  int cyc_n  = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  dma_trig_ctrl u_dma_trig_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt),
    .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .rd_addr_i(ra), .rd_data_o(rd),
    .start_valid_o(sv), .start_ready_i(rdy), .start_ch_o(sch),
    .done_valid_i(dv), .done_ch_i(dch), .done_final_i(dfin),
    .irq_o(irq)
  );

  // behavioural reference
  logic [N-1:0] m_ef, m_en, m_sf, m_cf, m_ip, m_ie, m_ms;
  logic [11:0]  m_opt [N];
  logic         m_ov;
  int           m_ch;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ef = '0; m_en = '0; m_sf = '0; m_cf = '0;
      m_ip = '0; m_ie = '0; m_ms = '0; m_ov = 1'b0; m_ch = 0;
      for (int i = 0; i < N; i++) m_opt[i] = '0;
    end else begin
      logic [N-1:0] pend, clr, ss, sc, ipset, miss, iclr, mclr;
      logic [11:0]  o;
      int           code;
      bit           acc;
      acc  = m_ov && rdy;
      clr  = '0;
      if (acc) clr[m_ch] = 1'b1;
      pend = (m_ef & m_en) | m_sf | m_cf;
      ipset = '0; sc = '0;
      if (dv) begin
        o = m_opt[dch];
        code = int'(o[7:0]);
        if (code < N) begin
          if (dfin ? o[8] : o[10]) ipset[code] = 1'b1;
          if (dfin ? o[9] : o[11]) sc[code] = 1'b1;
        end
      end
      ss   = (we && wa == 2) ? wd : '0;
      iclr = (we && wa == 5) ? wd : '0;
      mclr = (we && wa == 7) ? wd : '0;
      miss = ((evt & m_ef) | (ss & m_sf) | (sc & m_cf)) & ~clr;
      if (we && wa == 1) m_en = wd;
      if (we && wa == 6) m_ie = wd;
      for (int i = 0; i < N; i++) if (we && wa == 16 + i) m_opt[i] = wd[11:0];
      m_ms = (m_ms & ~mclr) | miss;
      m_ip = (m_ip & ~iclr) | ipset;
      m_ef = (m_ef & ~clr) | evt;
      m_sf = (m_sf & ~clr) | ss;
      m_cf = (m_cf & ~clr) | sc;
      if (m_ov) begin
        if (acc) m_ov = 1'b0;
      end else if (pend != '0) begin
        m_ov = 1'b1;
        for (int i = N - 1; i >= 0; i--) if (pend[i]) m_ch = i;
      end
    end
  end

  function automatic logic [DW-1:0] m_read(input int a);
    case (a)
      0: return m_ef;
      1: return m_en;
      2: return m_sf;
      3: return m_cf;
      4: return m_ip;
      6: return m_ie;
      7: return m_ms;
      default: return (a >= 16 && a < 16 + N) ? DW'(m_opt[a-16]) : '0;
    endcase
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h at cycle %0d", cur_req, what, act, exp, cyc_n);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    cyc_n++;
    chk("start_valid", int'(sv), int'(m_ov));
    if (m_ov) chk("start_ch", int'(sch), m_ch);
    chk("irq", int'(irq), int'((m_ip & m_ie) != '0));
    chk($sformatf("read@%0d", ra), int'(rd), int'(m_read(int'(ra))));
    evt = '0; we = 1'b0; dv = 1'b0;
    ra = AW'((int'(ra) + 1) % 32);
  endtask

  task automatic wr(input int a, input int d);
    we = 1'b1; wa = AW'(a); wd = DW'(d);
    cyc();
  endtask

  task automatic done(input int ch, input bit fin);
    dv = 1'b1; dch = CW'(ch); dfin = fin;
    cyc();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("reset start_valid", int'(sv), 0);
    chk("reset irq", int'(irq), 0);
    rst_n = 1'b1;
    idle(34);

    cur_req = "R2";
    evt = 16'h0008; cyc();
    idle(4);
    ra = '0; cyc();
    chk("event flag latched while disabled", int'(rd), 16'h0008);
    chk("no start while disabled", int'(sv), 0);
    wr(1, 16'h0008);
    idle(1);
    cur_req = "R5";
    chk("offer ch3", int'(sv), 1);
    idle(3);
    chk("offer held ch", int'(sch), 3);
    rdy = 1'b1; cyc();
    chk("gap after accept", int'(sv), 0);
    idle(3);

    cur_req = "R3";
    rdy = 1'b0;
    wr(2, 16'h0000);
    idle(2);
    chk("zero write starts nothing", int'(sv), 0);
    cur_req = "R4";
    wr(2, 16'h0024);
    cyc();
    chk("lowest first ch2", int'(sch), 2);
    rdy = 1'b1;
    idle(4);

    cur_req = "R6";
    wr(16 + 2, 12'h107);
    wr(16 + 9, 12'h40A);
    wr(6, 16'h0080);
    done(2, 1'b1);
    chk("ipend bit7 final", int'(irq), 1);
    done(9, 1'b0);
    done(9, 1'b1);
    ra = AW'(4); cyc();
    chk("ipend 7 and 10", int'(rd), 16'h0480);
    cur_req = "R8";
    wr(5, 16'h0080);
    chk("irq cleared", int'(irq), 0);
    dv = 1'b1; dch = CW'(9); dfin = 1'b0;
    wr(5, 16'h0400);
    ra = AW'(4); cyc();
    chk("set wins over clear", int'(rd), 16'h0400);
    wr(5, 16'h0400);

    cur_req = "R7";
    wr(16 + 1, 12'h206);
    wr(16 + 4, 12'h80B);
    wr(16 + 5, 12'h214);
    done(1, 1'b1);
    done(4, 1'b0);
    done(4, 1'b1);
    done(5, 1'b1);
    idle(8);
    ra = AW'(17); cyc();
    chk("option unchanged after chain", int'(rd), 12'h206);

    cur_req = "R9";
    rdy = 1'b0;
    wr(1, 16'h0001);
    evt = 16'h0001; cyc();
    evt = 16'h0001; cyc();
    wr(2, 16'h0001);
    ra = AW'(7); cyc();
    chk("missed ch0", int'(rd), 16'h0001);
    evt = 16'h0001;
    wr(7, 16'h0001);
    wr(7, 16'h0001);
    rdy = 1'b1;
    idle(4);

    cur_req = "R10";
    wr(0, 16'hFFFF);
    wr(3, 16'hFFFF);
    wr(4, 16'hFFFF);
    idle(3);
    ra = AW'(12); cyc();
    chk("unmapped reads zero", int'(rd), 0);
    idle(40);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule